// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps track of an on-chip packet memory that is cut into fixed 256-byte pages. A host reserves a run of pages with a single command and gets back a small packet number. Other commands hand packet numbers to a transmit queue, take them off a receive queue, and return pages to the pool. The MAC side sees two streams. One carries the numbers of freshly received packets into the receive queue. The other hands the head of the transmit queue to the transmitter.

Host commands arrive as an 8-bit word on a valid/ready stream. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the whole of a release window, so the host must hold or retry its command. The receive input stream takes a packet number only when `rxq_in_ready` is high. That signal depends on queue occupancy alone and never on `rxq_in_valid`. The transmit output stream shows the queue head whenever `txq_out_valid` is high, and pops it on a cycle where `txq_out_ready` is also high. Status words, the packet number register and the allocation pulse are plain registered signals.

Top module: `pkt_page_alloc`

## Requirements
- R1: The opcode is `cmd_word[7:5]`. 0 does nothing, 1 allocates, 2 resets the allocator, 3 drops the receive head, 4 drops the receive head and frees it, 5 frees the packet in the packet number register, 6 enqueues that packet for transmit, and 7 flushes the transmit queue.
- R2: Allocate takes `cmd_word[2:0]`+1 pages. It uses the lowest-addressed contiguous run of free pages and the lowest unused packet number. From the next cycle, `alloc_result` shows that number with bit 7 clear.
- R3: If no run fits or no packet number is free, `alloc_result` becomes 8'h80 and no page is taken.
- R4: `alloc_irq` is high for exactly the one cycle after a successful allocate is accepted, and never otherwise.
- R5: `fifo_status` is {receive empty, receive head[6:0], transmit empty, transmit head[6:0]}. A head field reads zero when its queue is empty.
- R6: `mem_info` is {free pages, total pages}, one byte each. It follows every allocation and release.
- R7: Opcodes 4 and 5 raise `busy` for exactly 4 cycles, starting the cycle after acceptance. The pages are returned on the edge where `busy` falls.
- R8: While `busy` is high, `cmd_ready` is low, and a presented command has no effect.
- R9: Opcode 3 pops the receive head and leaves its pages allocated. Opcode 4 pops it and frees its pages. On an empty queue both pop nothing.
- R10: Opcode 6 appends the packet number register to the transmit queue, or drops it if the queue is full. The transmitter pops the head through `txq_out_valid`/`txq_out_ready`.
- R11: Opcode 7 empties the transmit queue and leaves the receive queue and the pages unchanged.
- R12: Opcode 2 frees every page and packet number, empties both queues and clears `alloc_result`, all in one cycle. It wins over a same-cycle push or pop.
- R13: `rxq_in_ready` is high exactly when the receive queue is not full. A number offered while it is low is dropped.
- R14: Opcode 5 naming a packet that is not allocated, or a number of 8 or more, changes no page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_word | input | 8 | Opcode in 7:5, page count minus one in 2:0 |
| pnr_we | input | 1 | Write strobe for the packet number register |
| pnr_wdata | input | 7 | Packet number to store |
| pnr_q | output | 7 | Packet number register contents |
| alloc_result | output | 8 | Fail flag in bit 7, packet number below |
| alloc_irq | output | 1 | One-cycle pulse on allocation success |
| busy | output | 1 | Release in progress |
| fifo_status | output | 16 | Queue empty flags and head numbers |
| mem_info | output | 16 | Free pages (high byte), total pages (low byte) |
| rxq_in_valid | input | 1 | Receive packet number offered |
| rxq_in_ready | output | 1 | Receive queue has room |
| rxq_in_pkt | input | 7 | Receive packet number |
| txq_out_valid | output | 1 | Transmit queue not empty |
| txq_out_ready | input | 1 | Transmitter takes the head |
| txq_out_pkt | output | 7 | Transmit queue head |

## Verification
Each queue can be pushed and popped in the same cycle by different agents. The MAC can push a received number while the host's opcode 3 or 4 pops the receive head. The host's opcode 6 can append to the transmit queue while the transmitter pops it. A reset command can also meet a MAC push. Directed steps line these up on one clock, including pushes into an empty queue and into a full one. A long random phase drives all three sources freely. A behavioural model built on lists and integer arrays predicts every output, and the outputs are compared with it after every edge.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int PKT_NUM_W = 7;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RX_DROP  = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_FREE_PNR = 3'd5,
    OP_TX_ENQ   = 3'd6,
    OP_TX_FLUSH = 3'd7
  } pa_op_e;
endpackage

// File: rtl/pa_pkt_fifo.sv
module pa_pkt_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/pa_release_timer.sv
module pa_release_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= CW'(CYCLES);
    else if (busy)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/pa_page_map.sv
module pa_page_map #(
  parameter int NUM_PAGES = 16,
  parameter int NUM_PKTS  = 8,
  parameter int REQ_W     = 3,
  parameter int PKT_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             alloc_req,
  input  logic [REQ_W:0]   alloc_npg,
  output logic             alloc_ok,
  output logic [PKT_W-1:0] alloc_pkt,
  input  logic             free_req,
  input  logic [PKT_W-1:0] free_pkt,
  output logic [7:0]       free_pages
);
  localparam int MAX_RUN = 1 << REQ_W;
  localparam int MW      = NUM_PAGES + MAX_RUN;
  localparam int PG_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int SL_W    = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;

  logic [NUM_PAGES-1:0] used;
  logic [NUM_PKTS-1:0]  slot_used;
  logic [PG_W-1:0]      slot_start [NUM_PKTS];
  logic [REQ_W:0]       slot_len   [NUM_PKTS];

  logic                 fit_found, slot_found, free_hit;
  logic [PG_W-1:0]      fit_start;
  logic [SL_W-1:0]      slot_idx, free_idx;
  logic [MW-1:0]        fit_mask, free_mask;
  logic [NUM_PAGES-1:0] set_bits, clr_bits;

  function automatic logic [MW-1:0] run_mask(input logic [PG_W-1:0] st,
                                             input logic [REQ_W:0]  len);
    return ((MW'(1) << len) - MW'(1)) << st;
  endfunction

  // lowest-addressed contiguous run of free pages
  always_comb begin
    logic [MW-1:0] m;
    fit_found = 1'b0;
    fit_start = '0;
    for (int s = NUM_PAGES - 1; s >= 0; s--) begin
      m = run_mask(PG_W'(s), alloc_npg);
      if (m[MW-1:NUM_PAGES] == '0 && (m[NUM_PAGES-1:0] & used) == '0) begin
        fit_found = 1'b1;
        fit_start = PG_W'(s);
      end
    end
  end

  // lowest unused packet number
  always_comb begin
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = NUM_PKTS - 1; i >= 0; i--) begin
      if (!slot_used[i]) begin
        slot_found = 1'b1;
        slot_idx   = SL_W'(i);
      end
    end
  end

  assign alloc_ok  = fit_found && slot_found;
  assign alloc_pkt = PKT_W'(slot_idx);
  assign fit_mask  = run_mask(fit_start, alloc_npg);

  assign free_idx  = free_pkt[SL_W-1:0];
  assign free_hit  = free_req && (free_pkt < PKT_W'(NUM_PKTS)) && slot_used[free_idx];
  assign free_mask = run_mask(slot_start[free_idx], slot_len[free_idx]);

  assign set_bits  = (alloc_req && alloc_ok) ? fit_mask[NUM_PAGES-1:0] : '0;
  assign clr_bits  = free_hit ? free_mask[NUM_PAGES-1:0] : '0;

  assign free_pages = 8'($countones(~used));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      used      <= '0;
      slot_used <= '0;
    end else begin
      used <= (used | set_bits) & ~clr_bits;
      if (free_hit)              slot_used[free_idx] <= 1'b0;
      if (alloc_req && alloc_ok) slot_used[slot_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_req && alloc_ok) begin
      slot_start[slot_idx] <= fit_start;
      slot_len[slot_idx]   <= alloc_npg;
    end
  end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
  import pa_pkg::*;
#(
  parameter int NUM_PAGES      = 16,
  parameter int NUM_PKTS       = 8,
  parameter int REQ_W          = 3,
  parameter int RELEASE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_word,
  input  logic       pnr_we,
  input  logic [6:0] pnr_wdata,
  output logic [6:0] pnr_q,
  output logic [7:0] alloc_result,
  output logic       alloc_irq,
  output logic       busy,
  output logic [15:0] fifo_status,
  output logic [15:0] mem_info,
  input  logic       rxq_in_valid,
  output logic       rxq_in_ready,
  input  logic [6:0] rxq_in_pkt,
  output logic       txq_out_valid,
  input  logic       txq_out_ready,
  output logic [6:0] txq_out_pkt
);
  localparam int PW = PKT_NUM_W;

  logic           acc;
  logic [2:0]     op;
  logic [REQ_W:0] npg;
  logic           is_alloc, is_reset, is_rx_drop, is_rx_free;
  logic           is_free_pnr, is_tx_enq, is_tx_flush;
  logic           rx_empty, rx_full, tx_empty, tx_full;
  logic [PW-1:0]  rx_head, tx_head;
  logic           rel_start, rel_done;
  logic           pend_v;
  logic [PW-1:0]  pend_pkt;
  logic           map_ok;
  logic [PW-1:0]  map_pkt;
  logic [7:0]     free_pages;
  logic [PW-1:0]  pnr;

  assign acc       = cmd_valid && !busy;
  assign cmd_ready = !busy;
  assign op        = cmd_word[7:5];
  assign npg       = {1'b0, cmd_word[REQ_W-1:0]} + (REQ_W+1)'(1);

  assign is_alloc    = acc && (op == OP_ALLOC);
  assign is_reset    = acc && (op == OP_RESET);
  assign is_rx_drop  = acc && (op == OP_RX_DROP);
  assign is_rx_free  = acc && (op == OP_RX_FREE);
  assign is_free_pnr = acc && (op == OP_FREE_PNR);
  assign is_tx_enq   = acc && (op == OP_TX_ENQ);
  assign is_tx_flush = acc && (op == OP_TX_FLUSH);

  pa_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(is_reset),
    .push(rxq_in_valid), .din(rxq_in_pkt),
    .pop(is_rx_drop || is_rx_free),
    .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  pa_pkt_fifo #(.DEPTH(NUM_PKTS), .W(PW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(is_reset || is_tx_flush),
    .push(is_tx_enq), .din(pnr),
    .pop(txq_out_ready),
    .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  assign rel_start = is_rx_free || is_free_pnr;

  pa_release_timer #(.CYCLES(RELEASE_CYCLES)) u_rel (
    .clk(clk), .rst_n(rst_n), .start(rel_start), .busy(busy), .done(rel_done)
  );

  pa_page_map #(
    .NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS), .REQ_W(REQ_W), .PKT_W(PW)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .clr(is_reset),
    .alloc_req(is_alloc), .alloc_npg(npg),
    .alloc_ok(map_ok), .alloc_pkt(map_pkt),
    .free_req(rel_done && pend_v), .free_pkt(pend_pkt),
    .free_pages(free_pages)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_pkt <= '0;
    end else if (rel_start) begin
      pend_v   <= is_free_pnr || !rx_empty;
      pend_pkt <= is_free_pnr ? pnr : rx_head;
    end else if (rel_done) begin
      pend_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_result <= '0;
      alloc_irq    <= 1'b0;
      pnr          <= '0;
    end else begin
      alloc_irq <= is_alloc && map_ok;
      if (is_reset)      alloc_result <= '0;
      else if (is_alloc) alloc_result <= map_ok ? {1'b0, map_pkt} : 8'h80;
      if (pnr_we) pnr <= pnr_wdata;
    end
  end

  assign pnr_q         = pnr;
  assign rxq_in_ready  = !rx_full;
  assign txq_out_valid = !tx_empty;
  assign txq_out_pkt   = tx_head;
  assign fifo_status   = {rx_empty, rx_head, tx_empty, tx_head};
  assign mem_info      = {free_pages, 8'(NUM_PAGES)};
endmodule

// File: rtl/pa_alloc_checker.sv
module pa_alloc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_word,
  input logic        busy,
  input logic        alloc_irq,
  input logic [7:0]  alloc_result,
  input logic [15:0] fifo_status,
  input logic [15:0] mem_info
);
  logic taken;
  assign taken = cmd_valid && cmd_ready;

  assert_busy_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    taken && (cmd_word[7:5] == 3'd4 || cmd_word[7:5] == 3'd5) |=> busy);

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq |-> $past(taken && cmd_word[7:5] == 3'd1));

  assert_irq_result_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_irq |-> !alloc_result[7]);

  assert_fail_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_result[7] |-> alloc_result[6:0] == 7'd0);

  assert_free_le_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_info[15:8] <= mem_info[7:0]);

  assert_empty_heads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_status[15] |-> fifo_status[14:8] == 7'd0) and
    (fifo_status[7]  |-> fifo_status[6:0]  == 7'd0));

  assert_reset_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    taken && cmd_word[7:5] == 3'd2 |=>
      fifo_status[15] && fifo_status[7] && mem_info[15:8] == mem_info[7:0]
      && alloc_result == 8'h00);
endmodule

bind pkt_page_alloc pa_alloc_checker u_pa_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_word(cmd_word), .busy(busy), .alloc_irq(alloc_irq),
  .alloc_result(alloc_result), .fifo_status(fifo_status), .mem_info(mem_info)
);

// File: tb/test_pkt_page_alloc.sv
`timescale 1ns/1ps
module test_pkt_page_alloc;
  localparam int NP  = 16;
  localparam int NK  = 8;
  localparam int REL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_word = '0;
  logic pnr_we = 1'b0;
  logic [6:0] pnr_wdata = '0;
  logic rxq_in_valid = 1'b0;
  logic [6:0] rxq_in_pkt = '0;
  logic txq_out_ready = 1'b0;
  logic cmd_ready, alloc_irq, busy, rxq_in_ready, txq_out_valid;
  logic [6:0] pnr_q, txq_out_pkt;
  logic [7:0] alloc_result;
  logic [15:0] fifo_status, mem_info;

  always #2 clk = ~clk;

  pkt_page_alloc i_pkt_page_alloc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .pnr_we(pnr_we), .pnr_wdata(pnr_wdata), .pnr_q(pnr_q),
    .alloc_result(alloc_result), .alloc_irq(alloc_irq), .busy(busy),
    .fifo_status(fifo_status), .mem_info(mem_info),
    .rxq_in_valid(rxq_in_valid), .rxq_in_ready(rxq_in_ready), .rxq_in_pkt(rxq_in_pkt),
    .txq_out_valid(txq_out_valid), .txq_out_ready(txq_out_ready), .txq_out_pkt(txq_out_pkt)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_used [NP];
  bit m_su [NK];
  int m_st [NK];
  int m_ln [NK];
  int rxq[$];
  int txq[$];
  int m_result, m_busy, m_pp, m_pnr;
  bit m_irq, m_pv;

  function automatic int m_free_cnt();
    int c = 0;
    for (int i = 0; i < NP; i++) if (!m_used[i]) c++;
    return c;
  endfunction

  function automatic void m_free(input int p);
    if (p < NK && m_su[p]) begin
      for (int k = 0; k < m_ln[p]; k++) m_used[m_st[p] + k] = 0;
      m_su[p] = 0;
    end
  endfunction

  function automatic void m_reset_all();
    for (int i = 0; i < NP; i++) m_used[i] = 0;
    for (int i = 0; i < NK; i++) m_su[i] = 0;
    rxq.delete();
    txq.delete();
    m_result = 0;
  endfunction

  function automatic void m_alloc(input int n);
    int slot = -1;
    int start = -1;
    for (int i = NK - 1; i >= 0; i--) if (!m_su[i]) slot = i;
    for (int s = NP - n; s >= 0; s--) begin
      bit ok = 1;
      for (int k = 0; k < n; k++) if (m_used[s + k]) ok = 0;
      if (ok) start = s;
    end
    if (slot >= 0 && start >= 0) begin
      for (int k = 0; k < n; k++) m_used[start + k] = 1;
      m_su[slot] = 1; m_st[slot] = start; m_ln[slot] = n;
      m_result = slot;
      m_irq = 1;
    end else begin
      m_result = 'h80;
    end
  endfunction

  always @(posedge clk) begin : model
    bit acc, txpop, rxpush, rxpop, txpush;
    int op, rxh;
    if (!rst_n) begin
      m_reset_all();
      m_irq = 0; m_busy = 0; m_pv = 0; m_pp = 0; m_pnr = 0;
    end else begin
      acc    = cmd_valid && (m_busy == 0);
      op     = int'(cmd_word[7:5]);
      txpop  = txq_out_ready && txq.size() > 0;
      rxpush = rxq_in_valid && rxq.size() < NK;
      rxpop  = acc && (op == 3 || op == 4) && rxq.size() > 0;
      txpush = acc && op == 6 && txq.size() < NK;
      rxh    = (rxq.size() > 0) ? rxq[0] : 0;
      m_irq  = 0;
      if (m_busy > 0) begin
        if (m_busy == 1) begin
          if (m_pv) m_free(m_pp);
          m_pv = 0;
        end
        m_busy--;
      end
      if (txpop) void'(txq.pop_front());
      if (rxpop) void'(rxq.pop_front());
      if (rxpush) rxq.push_back(int'(rxq_in_pkt));
      if (txpush) txq.push_back(m_pnr);
      if (acc) begin
        case (op)
          1: m_alloc(int'(cmd_word[2:0]) + 1);
          2: m_reset_all();
          4: begin m_busy = REL; m_pv = rxq.size() > 0 || rxpop; m_pp = rxh; end
          5: begin m_busy = REL; m_pv = 1; m_pp = m_pnr; end
          7: txq.delete();
          default: ;
        endcase
      end
      if (pnr_we) m_pnr = int'(pnr_wdata);
    end
  end

  function automatic logic [15:0] exp_status();
    logic [15:0] v;
    v[15]   = rxq.size() == 0;
    v[14:8] = (rxq.size() > 0) ? 7'(rxq[0]) : 7'd0;
    v[7]    = txq.size() == 0;
    v[6:0]  = (txq.size() > 0) ? 7'(txq[0]) : 7'd0;
    return v;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 cmd_ready",    {31'd0, cmd_ready},    {31'd0, m_busy == 0});
      chk("R7 busy",         {31'd0, busy},         {31'd0, m_busy != 0});
      chk("R2 alloc_result", {24'd0, alloc_result}, 32'(m_result));
      chk("R4 alloc_irq",    {31'd0, alloc_irq},    {31'd0, m_irq});
      chk("R5 fifo_status",  {16'd0, fifo_status},  {16'd0, exp_status()});
      chk("R6 mem_info",     {16'd0, mem_info},     {16'd0, 8'(m_free_cnt()), 8'(NP)});
      chk("R13 rxq_in_ready",{31'd0, rxq_in_ready}, {31'd0, rxq.size() < NK});
      chk("R10 txq_out_valid",{31'd0, txq_out_valid},{31'd0, txq.size() > 0});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cmd(input int op, input int arg);
    cmd_valid = 1'b1;
    cmd_word  = {3'(op), 5'(arg)};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic set_pnr(input int v);
    pnr_we = 1'b1; pnr_wdata = 7'(v);
    @(negedge clk);
    pnr_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rx_push(input int p);
    rxq_in_valid = 1'b1; rxq_in_pkt = 7'(p);
    @(negedge clk);
    rxq_in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset mem_info", {16'd0, mem_info}, 32'h1010);
    chk("R5 reset status", {16'd0, fifo_status}, 32'h8080);

    cmd(0, 0);
    chk("R1 nop keeps pages", {24'd0, mem_info[15:8]}, 32'd16);
    cmd(1, 0);  // pkt0 page 0
    chk("R2 first alloc pkt0", {24'd0, alloc_result}, 32'h00);
    chk("R4 irq pulse", {31'd0, alloc_irq}, 32'd1);
    cmd(1, 3);  // pkt1 pages 1-4
    cmd(1, 7);  // pkt2 pages 5-12
    chk("R2 third alloc pkt2", {24'd0, alloc_result}, 32'h02);
    cmd(1, 3);  // 4 pages, only 3 free
    chk("R3 fail code", {24'd0, alloc_result}, 32'h80);
    chk("R3 no pages taken", {24'd0, mem_info[15:8]}, 32'd3);
    chk("R4 no irq on fail", {31'd0, alloc_irq}, 32'd0);
    cmd(1, 2);  // pkt3 pages 13-15

    set_pnr(1);
    cmd(5, 0);
    chk("R7 busy raised", {31'd0, busy}, 32'd1);
    cmd(1, 0);  // offered while busy: ignored
    chk("R8 ignored while busy", {24'd0, alloc_result}, 32'h03);
    wait_idle();
    chk("R7 pages back", {24'd0, mem_info[15:8]}, 32'd4);
    cmd(1, 1);  // first fit: pages 1-2, pkt1
    chk("R2 first fit hole", {24'd0, alloc_result}, 32'h01);

    // receive queue: push while dropping head in the same cycle
    rx_push(2);
    rxq_in_valid = 1'b1; rxq_in_pkt = 7'd0;
    cmd(3, 0);
    rxq_in_valid = 1'b0;
    chk("R9 drop keeps pages", {24'd0, mem_info[15:8]}, 32'd2);
    chk("R9 head after drop", {25'd0, fifo_status[14:8]}, 32'd0);
    rx_push(2);
    cmd(3, 0);  // head 0 dropped, 2 remains
    cmd(4, 0);  // drop and free pkt2
    wait_idle();
    chk("R9 free via rx", {24'd0, mem_info[15:8]}, 32'd10);

    set_pnr(5);
    cmd(5, 0);
    wait_idle();
    chk("R14 free unused", {24'd0, mem_info[15:8]}, 32'd10);
    set_pnr(100);
    cmd(5, 0);
    wait_idle();
    chk("R14 free out of range", {24'd0, mem_info[15:8]}, 32'd10);

    // transmit queue with same-cycle enqueue and pop
    set_pnr(3);
    cmd(6, 0);
    chk("R10 head", {25'd0, txq_out_pkt}, 32'd3);
    set_pnr(0);
    txq_out_ready = 1'b1;
    cmd(6, 0);
    txq_out_ready = 1'b0;
    chk("R10 enq with pop", {25'd0, txq_out_pkt}, 32'd0);
    for (int i = 0; i < NK + 2; i++) cmd(6, 0);
    chk("R10 full drop", {31'd0, txq_out_valid}, 32'd1);
    rx_push(1);
    cmd(7, 0);
    chk("R11 flush tx", {24'd0, fifo_status[7:0]}, 32'h80);
    chk("R11 rx kept", {31'd0, fifo_status[15]}, 32'd0);
    for (int i = 0; i < NK + 1; i++) rx_push(i);
    chk("R13 rx full", {31'd0, rxq_in_ready}, 32'd0);

    rxq_in_valid = 1'b1; rxq_in_pkt = 7'd4;
    cmd(2, 0);
    rxq_in_valid = 1'b0;
    chk("R12 reset status", {16'd0, fifo_status}, 32'h8080);
    chk("R12 reset pages", {16'd0, mem_info}, 32'h1010);
    chk("R12 reset result", {24'd0, alloc_result}, 32'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 40;
      cmd_valid     = ($urandom % 3) == 0;
      cmd_word      = {(r == 0) ? 3'd2 : 3'(($urandom % 7 == 0) ? 1 : $urandom % 8),
                       5'($urandom)};
      if (cmd_word[7:5] == 3'd2 && r != 0) cmd_word[7:5] = 3'd1;
      pnr_we        = ($urandom % 5) == 0;
      pnr_wdata     = 7'($urandom % 10);
      rxq_in_valid  = ($urandom % 5) < 2;
      rxq_in_pkt    = 7'($urandom % NK);
      txq_out_ready = $urandom % 2;
      @(negedge clk);
    end
    cmd_valid = 0; pnr_we = 0; rxq_in_valid = 0; txq_out_ready = 0;
    @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule